// File: doc/BRIEF.md
# Timestamped Event Capture Unit

This block sits on a lane node and watches a set of digital event inputs: pushbuttons, touch pads, a relay take-off platform and start inputs. Each input is brought into the clock domain by a two-flop synchronizer. It is then filtered by a debounce that counts millisecond ticks. Each input then reports its rising edge (activation), its falling edge (release), both, or neither, as chosen per input.

Every reported edge becomes a self-describing record. The record holds the local millisecond time, the index of the input that fired, the new level, the node's own identifier and an overflow marker. Edges that occur in the same cycle receive the same time and leave in ascending input order. Records wait in a small FIFO and leave on a valid/ready stream toward a packetizer.

The millisecond counter can be loaded or nudged by a signed correction, so that an external synchronization engine can slew it.

Top module: `evcap_top`

## Requirements
- R1: With `debounce_ms` = N > 0, a synchronized level change on an input is accepted only once it has stayed different from the accepted level across N consecutive millisecond ticks. A return to the accepted level restarts the count. With N = 0 the change is accepted right after the synchronizer.
- R2: For input i, `trig_mode[2i]` enables reporting of its rising edge and `trig_mode[2i+1]` enables reporting of its falling edge. An edge whose bit is 0 produces no record.
- R3: `ts_now` increases by exactly one every CLK_PER_MS clock cycles and wraps modulo 2^16.
- R4: A pulse on `ts_load` sets `ts_now` to `ts_load_val` on the next edge, taking precedence over the tick and the correction. A pulse on `ts_adj_valid` adds the signed `ts_adj` to the count, on top of any tick in that cycle.
- R5: Record layout: bits [15:0] hold the timestamp, [23:16] the node identifier, [26:24] the input index as the event code, [27] the new level (1 for activation), and [28] the overflow marker.
- R6: The timestamp of a record is the value of `ts_now` in the cycle in which the accepted level changed. Edges accepted in the same cycle carry identical timestamps.
- R7: Pending events are moved into the FIFO one per cycle, lowest input index first.
- R8: `out_valid` is high whenever the FIFO holds a record. While `out_valid` is high and `out_ready` is low, `out_rec` is held stable.
- R9: A granted event that finds the FIFO full is discarded, and so is a pending event that is overwritten by a new edge on the same input. Either case sets `ovf_flag`.
- R10: The first record written into the FIFO after a discard carries bit 28 = 1, and writing it clears `ovf_flag` unless a new discard occurs in the same cycle.
- R11: After reset, `ts_now` is 0, `out_valid` is 0 and `ovf_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | NUM_IN | Raw event input levels |
| trig_mode | input | 2*NUM_IN | Per-input edge enables (rise, fall) |
| debounce_ms | input | DEB_W | Debounce length in ms ticks |
| node_id | input | 8 | Origin identifier written into records |
| ts_load | input | 1 | Load pulse for the ms counter |
| ts_load_val | input | 16 | Value to load |
| ts_adj_valid | input | 1 | Correction pulse |
| ts_adj | input | 16 | Signed correction added to the counter |
| ts_now | output | 16 | Current millisecond count |
| ovf_flag | output | 1 | Sticky discard flag |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer accepts the record |
| out_rec | output | 29 | Event record |

## Verification
The hardest state to reach from the ports is a discard followed by a marked record. It needs more grants than free FIFO slots while the consumer is stalled. The stimulus holds `out_ready` low and raises all eight inputs in one cycle with zero debounce, so four events fill the FIFO and four are discarded. It then reopens the stream, drains, and releases one input, and the record that release produces must be the one carrying the marker. A behavioural model in the bench follows every input pattern clock by clock, so the ordering of same-tick edges and the timestamps around load, correction and wrap are compared in every cycle.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
    localparam int TS_W   = 16;
    localparam int NODE_W = 8;
    localparam int CODE_W = 3;
    localparam int REC_W  = 2 + CODE_W + NODE_W + TS_W;

    typedef struct packed {
        logic              ovf;
        logic              lvl;
        logic [CODE_W-1:0] code;
        logic [NODE_W-1:0] node;
        logic [TS_W-1:0]   ts;
    } ev_rec_t;

    typedef struct packed {
        logic            lvl;
        logic [TS_W-1:0] ts;
    } slot_t;

    function automatic logic edge_enabled(input logic new_lvl, input logic [1:0] mode);
        return new_lvl ? mode[0] : mode[1];
    endfunction
endpackage

// File: rtl/evcap_timebase.sv
module evcap_timebase
    import evcap_pkg::*;
#(
    parameter int CLK_PER_MS = 50000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld,
    input  logic [TS_W-1:0] ld_val,
    input  logic            adj_v,
    input  logic [TS_W-1:0] adj,
    output logic            tick,
    output logic [TS_W-1:0] ts
);
    localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_MS - 1);

    logic [PW-1:0] pre;

    assign tick = (pre == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre <= '0;
            ts  <= '0;
        end else begin
            pre <= tick ? '0 : pre + PW'(1);
            if (ld)
                ts <= ld_val;
            else
                ts <= ts + {{(TS_W-1){1'b0}}, tick} + (adj_v ? adj : '0);
        end
    end
endmodule

// File: rtl/evcap_cond.sv
module evcap_cond
    import evcap_pkg::*;
#(
    parameter int DEB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             din,
    input  logic [DEB_W-1:0] deb_n,
    input  logic [1:0]       mode,
    output logic             fire,
    output logic             lvl
);
    logic s1, s2, deb, deb_q;
    logic [DEB_W-1:0] cnt;

    assign lvl  = deb;
    assign fire = (deb ^ deb_q) & edge_enabled(deb, mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            deb   <= 1'b0;
            deb_q <= 1'b0;
            cnt   <= '0;
        end else begin
            s1    <= din;
            s2    <= s1;
            deb_q <= deb;
            if (s2 == deb) begin
                cnt <= '0;
            end else if (deb_n == '0) begin
                deb <= s2;
                cnt <= '0;
            end else if (tick) begin
                if (cnt == deb_n - DEB_W'(1)) begin
                    deb <= s2;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + DEB_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/evcap_arb.sv
module evcap_arb
    import evcap_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] fire,
    input  logic [NUM_IN-1:0] lvl,
    input  logic [TS_W-1:0]   ts,
    input  logic              can_push,
    output logic              push,
    output logic [CODE_W-1:0] code,
    output slot_t             slot,
    output logic              drop,
    output logic [NUM_IN-1:0] gnt
);
    logic [NUM_IN-1:0] pend;
    slot_t             slots [NUM_IN];
    logic              found;

    always_comb begin
        gnt   = '0;
        code  = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (pend[i] && !found) begin
                gnt[i] = 1'b1;
                code   = CODE_W'(i);
                found  = 1'b1;
            end
        end
    end

    assign slot = slots[code];
    assign push = found & can_push;
    assign drop = (found & ~can_push) | (|(fire & pend & ~gnt));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~gnt) | fire;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_IN; i++) begin
            if (fire[i]) slots[i] <= '{lvl: lvl[i], ts: ts};
        end
    end
endmodule

// File: rtl/evcap_fifo.sv
module evcap_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 29
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = wr_en & ~full;
    assign do_rd   = rd_en & ~empty;
    assign rd_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
            if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
            count <= count + CW'(do_wr) - CW'(do_rd);
        end
    end
endmodule

// File: rtl/evcap_top.sv
module evcap_top
    import evcap_pkg::*;
#(
    parameter int NUM_IN     = 8,
    parameter int CLK_PER_MS = 50000,
    parameter int DEPTH      = 8,
    parameter int DEB_W      = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_IN-1:0]      ev_in,
    input  logic [2*NUM_IN-1:0]    trig_mode,
    input  logic [DEB_W-1:0]       debounce_ms,
    input  logic [NODE_W-1:0]      node_id,
    input  logic                   ts_load,
    input  logic [TS_W-1:0]        ts_load_val,
    input  logic                   ts_adj_valid,
    input  logic signed [TS_W-1:0] ts_adj,
    output logic [TS_W-1:0]        ts_now,
    output logic                   ovf_flag,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [REC_W-1:0]       out_rec
);
    logic              tick;
    logic [NUM_IN-1:0] fire, lvl, gnt;
    logic              push_fire, drop, fifo_full, fifo_empty;
    logic [CODE_W-1:0] code;
    slot_t             slot;
    ev_rec_t           wr_rec;
    logic              ovf_q;

    evcap_timebase #(.CLK_PER_MS(CLK_PER_MS)) u_tb (
        .clk(clk), .rst(rst), .ld(ts_load), .ld_val(ts_load_val),
        .adj_v(ts_adj_valid), .adj($unsigned(ts_adj)), .tick(tick), .ts(ts_now)
    );

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        evcap_cond #(.DEB_W(DEB_W)) u_cond (
            .clk(clk), .rst(rst), .tick(tick), .din(ev_in[i]),
            .deb_n(debounce_ms), .mode(trig_mode[2*i +: 2]),
            .fire(fire[i]), .lvl(lvl[i])
        );
    end

    evcap_arb #(.NUM_IN(NUM_IN)) u_arb (
        .clk(clk), .rst(rst), .fire(fire), .lvl(lvl), .ts(ts_now),
        .can_push(~fifo_full), .push(push_fire), .code(code), .slot(slot),
        .drop(drop), .gnt(gnt)
    );

    assign wr_rec = '{ovf: ovf_q, lvl: slot.lvl, code: code, node: node_id, ts: slot.ts};

    always_ff @(posedge clk) begin
        if (rst) ovf_q <= 1'b0;
        else     ovf_q <= (ovf_q & ~push_fire) | drop;
    end

    evcap_fifo #(.DEPTH(DEPTH), .W(REC_W)) u_fifo (
        .clk(clk), .rst(rst), .wr_en(push_fire), .wr_data(wr_rec),
        .rd_en(out_ready), .rd_data(out_rec), .full(fifo_full), .empty(fifo_empty)
    );

    assign out_valid = ~fifo_empty;
    assign ovf_flag  = ovf_q;
endmodule

// File: rtl/evcap_checker.sv
module evcap_checker
    import evcap_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic              out_ready,
    input logic [REC_W-1:0]  out_rec,
    input logic [TS_W-1:0]   ts_now,
    input logic              ts_load,
    input logic [TS_W-1:0]   ts_load_val,
    input logic              ts_adj_valid,
    input logic              ovf_flag,
    input logic              push_fire,
    input logic              tick,
    input logic [NUM_IN-1:0] gnt
);
    localparam logic [TS_W-1:0] ONE = {{(TS_W-1){1'b0}}, 1'b1};

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_rec));

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        !ts_load && !ts_adj_valid |=> (ts_now == $past(ts_now)) || (ts_now == $past(ts_now) + ONE));

    a_r3_tick: assert property (@(posedge clk) disable iff (rst)
        tick && !ts_load && !ts_adj_valid |=> ts_now == $past(ts_now) + ONE);

    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        ts_load |=> ts_now == $past(ts_load_val));

    a_r7_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_flag) |-> $past(push_fire));

    a_r11_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid && ts_now == '0 && !ovf_flag);
endmodule

bind evcap_top evcap_checker #(.NUM_IN(NUM_IN)) u_chk (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
    .out_rec(out_rec), .ts_now(ts_now), .ts_load(ts_load),
    .ts_load_val(ts_load_val), .ts_adj_valid(ts_adj_valid),
    .ovf_flag(ovf_flag), .push_fire(push_fire), .tick(tick), .gnt(gnt)
);

// File: tb/sim_evcap_top.sv
module sim_evcap_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPM   = 20;
    localparam int DEPTH = 4;
    localparam logic [7:0] NODE = 8'h5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ev = '0;
    logic [15:0] mode = '0;
    logic [3:0]  debn = '0;
    logic        ld = 1'b0;
    logic [15:0] ldv = '0;
    logic        adjv = 1'b0;
    logic signed [15:0] adj = '0;
    logic        rdy = 1'b1;
    logic [15:0] ts_now;
    logic        ovf, ov;
    logic [28:0] orec;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evcap_top #(.NUM_IN(8), .CLK_PER_MS(CPM), .DEPTH(DEPTH), .DEB_W(4)) u0 (
        .clk(clk), .rst(rst), .ev_in(ev), .trig_mode(mode), .debounce_ms(debn),
        .node_id(NODE), .ts_load(ld), .ts_load_val(ldv), .ts_adj_valid(adjv),
        .ts_adj(adj), .ts_now(ts_now), .ovf_flag(ovf), .out_valid(ov),
        .out_ready(rdy), .out_rec(orec)
    );

    task automatic chk(input bit c, input string tag, input longint act, input longint exp);
        total++;
        if (!c) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [7:0]  m_s1, m_s2, m_deb, m_debq, m_pend, m_plvl;
    int          m_cnt [8];
    logic [15:0] m_pts [8];
    logic [28:0] mq [$];
    logic [15:0] mts;
    int          mpre;
    logic        movf;

    always @(posedge clk) begin : model
        logic tk, full, drop, pushed, f;
        int g;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_deb = '0; m_debq = '0; m_pend = '0; m_plvl = '0;
            for (int i = 0; i < 8; i++) begin m_cnt[i] = 0; m_pts[i] = '0; end
            mq.delete(); mts = '0; mpre = 0; movf = 1'b0;
        end else begin
            tk = (mpre == CPM-1);
            full = (mq.size() == DEPTH);
            drop = 1'b0; pushed = 1'b0;
            if (mq.size() > 0 && rdy) void'(mq.pop_front());
            g = -1;
            for (int i = 0; i < 8; i++) if (m_pend[i] && g < 0) g = i;
            if (g >= 0) begin
                if (!full) begin
                    mq.push_back({movf, m_plvl[g], 3'(g), NODE, m_pts[g]});
                    pushed = 1'b1;
                end else drop = 1'b1;
                m_pend[g] = 1'b0;
            end
            for (int i = 0; i < 8; i++) begin
                f = (m_deb[i] != m_debq[i]) && (m_deb[i] ? mode[2*i] : mode[2*i+1]);
                if (f) begin
                    if (m_pend[i]) drop = 1'b1;
                    m_pend[i] = 1'b1; m_pts[i] = mts; m_plvl[i] = m_deb[i];
                end
            end
            movf = (movf && !pushed) || drop;
            m_debq = m_deb;
            for (int i = 0; i < 8; i++) begin
                if (m_s2[i] == m_deb[i]) m_cnt[i] = 0;
                else if (debn == 0) begin m_deb[i] = m_s2[i]; m_cnt[i] = 0; end
                else if (tk) begin
                    if (m_cnt[i] == int'(debn) - 1) begin m_deb[i] = m_s2[i]; m_cnt[i] = 0; end
                    else m_cnt[i]++;
                end
            end
            m_s2 = m_s1; m_s1 = ev;
            if (ld) mts = ldv;
            else mts = mts + {15'd0, tk} + (adjv ? $unsigned(adj) : 16'd0);
            mpre = tk ? 0 : mpre + 1;
        end
    end

    // clock-by-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(ts_now == mts, "R3/R4 ts_now", ts_now, mts);
            chk(ov == (mq.size() > 0), "R8 out_valid", ov, mq.size() > 0);
            if (ov && mq.size() > 0) chk(orec == mq[0], "R5/R6/R7 out_rec", orec, mq[0]);
            chk(ovf == movf, "R9 ovf_flag", ovf, movf);
        end
    end

    // stream statistics taken at the ports
    int nrec = 0, nmark = 0, nsame = 0, nbadorder = 0;
    logic [28:0] last_rec = '0;
    always @(posedge clk) begin
        if (!rst && ov && rdy) begin
            if (nrec > 0 && orec[15:0] == last_rec[15:0]) begin
                nsame++;
                if (orec[26:24] <= last_rec[26:24]) nbadorder++;
            end
            if (orec[28]) nmark++;
            last_rec = orec;
            nrec++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            summary();
            $finish;
        end
    end

    initial begin : stim
        int n0;
        logic [28:0] held;
        cyc(4);
        // R11: reset state
        chk(ts_now == 16'd0, "R11 ts_now", ts_now, 0);
        chk(ov == 1'b0, "R11 out_valid", ov, 0);
        chk(ovf == 1'b0, "R11 ovf_flag", ovf, 0);
        rst = 1'b0;
        mode = 16'hFFFF;
        cyc(5);

        // R6, R7: three inputs in one cycle
        n0 = nrec;
        ev = 8'b0010_1001;
        cyc(30);
        chk(nrec - n0 == 3, "R7 record count", nrec - n0, 3);
        chk(nsame >= 2, "R6 shared timestamp", nsame, 2);
        chk(nbadorder == 0, "R7 ascending order", nbadorder, 0);
        ev = 8'h00;
        cyc(30);
        chk(nrec - n0 == 6, "R2 release records", nrec - n0, 6);

        // R2: masked input 1, rise-only input 2
        mode = 16'hFFFF & ~(16'h3 << 2) & ~(16'h1 << 5);
        n0 = nrec;
        ev = 8'b0000_0010; cyc(30);
        ev = 8'h00; cyc(30);
        chk(nrec - n0 == 0, "R2 masked input", nrec - n0, 0);
        ev = 8'b0000_0100; cyc(30);
        // R5: field layout of a single record
        chk(last_rec[26:24] == 3'd2, "R5 code", last_rec[26:24], 2);
        chk(last_rec[23:16] == NODE, "R5 node", last_rec[23:16], NODE);
        chk(last_rec[27] == 1'b1, "R5 level", last_rec[27], 1);
        chk(last_rec[28] == 1'b0, "R5 marker", last_rec[28], 0);
        ev = 8'h00; cyc(30);
        chk(nrec - n0 == 1, "R2 rise only", nrec - n0, 1);

        // R1: debounce of 2 ms
        mode = 16'hFFFF;
        debn = 4'd2;
        n0 = nrec;
        ev = 8'b0001_0000; cyc(5);
        ev = 8'h00; cyc(80);
        chk(nrec - n0 == 0, "R1 glitch ignored", nrec - n0, 0);
        ev = 8'b0001_0000; cyc(80);
        chk(nrec - n0 == 1, "R1 held level", nrec - n0, 1);
        ev = 8'h00; cyc(80);
        chk(nrec - n0 == 2, "R1 held release", nrec - n0, 2);
        debn = 4'd0;

        // R4, R3: load, correction, wrap
        ld = 1'b1; ldv = 16'd1000; cyc(1);
        ld = 1'b0;
        chk(ts_now == 16'd1000, "R4 load", ts_now, 1000);
        cyc(40);
        chk(ts_now == 16'd1002, "R3 two ticks", ts_now, 1002);
        adjv = 1'b1; adj = -16'sd5; cyc(1);
        adjv = 1'b0; cyc(7);
        adjv = 1'b1; adj = 16'sd3; cyc(1);
        adjv = 1'b0; cyc(7);
        ld = 1'b1; ldv = 16'hFFFE; cyc(1);
        ld = 1'b0; cyc(70);

        // R9, R10: stalled stream, eight simultaneous events
        rdy = 1'b0;
        n0 = nrec;
        ev = 8'hFF; cyc(20);
        chk(ovf == 1'b1, "R9 flag set", ovf, 1);
        chk(ov == 1'b1, "R8 valid while stalled", ov, 1);
        held = orec;
        cyc(5);
        chk(orec == held, "R8 record held", orec, held);
        rdy = 1'b1; cyc(20);
        chk(nrec - n0 == DEPTH, "R9 kept records", nrec - n0, DEPTH);
        chk(nmark == 0, "R10 no early marker", nmark, 0);
        chk(ovf == 1'b1, "R9 flag sticky", ovf, 1);
        ev = 8'hFE; cyc(20);
        chk(nmark == 1, "R10 marker emitted", nmark, 1);
        chk(last_rec[28] == 1'b1 && last_rec[27] == 1'b0, "R10 marked release", last_rec[28:27], 2'b10);
        chk(ovf == 1'b0, "R10 flag cleared", ovf, 0);
        ev = 8'h00; cyc(40);

        done = 1;
        summary();
        $finish;
    end
endmodule